// File: doc/BRIEF.md
# Multi-Mode Conversion Sequencer for a Four-Input Converter

This block sits between software-visible controls and a four-input analog-to-digital converter. It decides which input the converter samples next and which of four result registers takes each returned sample. It also decides when to raise a sticky completion interrupt. A qualified start pulse from outside begins a sequence. The converter is driven through a one-cycle start request with a channel number, and it answers with a one-cycle done pulse carrying the sample.

Six sequencing modes are supported:

- **Fixed single:** one input, converted once.
- **Fixed continuous:** one input, converted repeatedly into rotating slots.
- **Scan single:** a pass over a selected subset of inputs.
- **Scan continuous:** repeated passes over the selected subset.
- **Paired continuous:** two chosen inputs, alternating into interleaved slots.
- **Stepped scan:** one selected input per start event.

The continuous modes keep running while the run control is high.

Top module: `adc_seq`

## Requirements
- R1: With mode code 0 (fixed single), a start converts `fix_ch` once, writes the sample to result register `fix_ch`, sets the interrupt pending flag and returns to idle.
- R2: With mode code 1 (fixed continuous), `fix_ch` is converted repeatedly and successive samples go to result registers 0, 1, 2, 3, then wrap to 0 and overwrite.
- R3: In mode code 1 the pending flag is set once per group of four samples (when slot 3 is written) if `group_irq_sel` is 1, and never if it is 0.
- R4: With mode code 2 (scan single), each channel set in `scan_mask` (bit i = channel i) is converted once in ascending index order into its own result register i; the flag is set only after the highest selected channel is written. A mask with one bit set behaves as mode 0 on that channel.
- R5: With mode code 3 (scan continuous), after the highest selected channel the scan restarts at the lowest selected channel, setting the flag at the end of every pass.
- R6: With mode code 4 (paired continuous), conversions follow `fix_ch` into slot 0, `pair_ch` into slot 1, `fix_ch` into slot 2, `pair_ch` into slot 3, repeating, and the flag is set each time slot 3 is written.
- R7: With mode code 5 (stepped scan), each start converts only the next selected channel in ascending order (wrapping to the lowest), writes it to its own register, sets the flag and returns to idle.
- R8: In modes 2, 3 and 5 an all-zero `scan_mask` makes a start do nothing: no converter request and no flag.
- R9: In modes 1, 3 and 4, a low `run` at the completion of a conversion stores that sample and then ends the sequence (`busy` falls) with no further request; result registers change only on a done pulse.
- R10: A start that arrives while `busy` is high is ignored and issues no converter request.
- R11: The pending flag stays set until a one-cycle `irq_clr` pulse; output `irq` is the flag gated by `irq_en`, so a flag set while disabled appears once `irq_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Mode code 0..5, sampled at start |
| fix_ch | input | 2 | Fixed channel, also first channel of the pair |
| pair_ch | input | 2 | Second channel of the pair |
| scan_mask | input | 4 | Channel selection for scan modes |
| start | input | 1 | Qualified start pulse |
| run | input | 1 | Continuous-mode enable, checked at each completion |
| irq_en | input | 1 | Interrupt output enable |
| group_irq_sel | input | 1 | Enables the group interrupt in fixed continuous mode |
| irq_clr | input | 1 | Write-one-to-clear for the pending flag |
| conv_start | output | 1 | One-cycle converter request |
| conv_ch | output | 2 | Channel for the converter request |
| conv_done | input | 1 | One-cycle converter completion |
| conv_data | input | DW | Converter sample, valid with conv_done |
| res | output | 4*DW | Result registers, register i at bits i*DW |
| busy | output | 1 | A sequence is active |
| irq | output | 1 | Masked interrupt |

## Verification
The bench goes after the placement rules where a wrong design would still look busy and correct. It checks the slot wrap after slot 3 in fixed continuous mode, where a stuck counter would keep overwriting one register. It checks the interleave of the paired mode, where a swapped select would put the second channel into even slots. It checks the ascending restart of a scan that skips an unselected channel, where a design would convert it or start mid-mask. It also checks the wrap of the stepped pointer from channel 3 back to channel 1.

Interrupt timing is probed one sample before and at each group boundary, so a flag raised every sample fails. Further cases cover:

- an empty mask, where a faulty design would request a conversion or hang busy;
- run dropped during the last conversion, where it would issue one extra request or drop the final sample;
- a second start during a conversion;
- a flag that is set while disabled and must appear once enabled.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode,
  input  logic [1:0]      fix_ch,
  input  logic [1:0]      pair_ch,
  input  logic [3:0]      scan_mask,
  input  logic            start,
  input  logic            run,
  input  logic            irq_en,
  input  logic            group_irq_sel,
  input  logic            irq_clr,
  output logic            conv_start,
  output logic [1:0]      conv_ch,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  output logic [4*DW-1:0] res,
  output logic            busy,
  output logic            irq
);
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  localparam logic [2:0] M_FSGL  = 3'd0;
  localparam logic [2:0] M_FCONT = 3'd1;
  localparam logic [2:0] M_SSGL  = 3'd2;
  localparam logic [2:0] M_SCONT = 3'd3;
  localparam logic [2:0] M_PAIR  = 3'd4;
  localparam logic [2:0] M_STEP  = 3'd5;

  function automatic logic [CW:0] first_at(input logic [NCH-1:0] m, input logic [CW-1:0] from);
    logic [CW:0] r;
    r = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (m[i] && i >= int'(from)) r = {1'b1, CW'(i)};
    return r;
  endfunction

  logic [2:0]     md_q;
  logic [NCH-1:0] msk_q;
  logic [CW-1:0]  a_q, b_q, slot_q, ptr_q;
  logic           pend_q;
  logic [DW-1:0]  rg [NCH];

  logic [CW:0] pick0, pickp, nh, low;
  assign pick0 = first_at(scan_mask, '0);
  assign pickp = first_at(scan_mask, ptr_q);
  assign low   = first_at(msk_q, '0);
  assign nh    = (conv_ch == CW'(NCH-1)) ? '0 : first_at(msk_q, conv_ch + CW'(1));

  logic          go_ok;
  logic [CW-1:0] go_ch;
  always_comb begin
    go_ok = 1'b0;
    go_ch = fix_ch;
    case (mode)
      M_FSGL, M_FCONT, M_PAIR: go_ok = 1'b1;
      M_SSGL, M_SCONT: begin
        go_ok = pick0[CW];
        go_ch = pick0[CW-1:0];
      end
      M_STEP: begin
        go_ok = pick0[CW];
        go_ch = pickp[CW] ? pickp[CW-1:0] : pick0[CW-1:0];
      end
      default: go_ok = 1'b0;
    endcase
  end

  logic          set_ev, more;
  logic [CW-1:0] dest, nch;
  always_comb begin
    dest   = conv_ch;
    set_ev = 1'b0;
    more   = 1'b0;
    nch    = conv_ch;
    case (md_q)
      M_FSGL: set_ev = 1'b1;
      M_FCONT: begin
        dest   = slot_q;
        set_ev = group_irq_sel && (slot_q == CW'(NCH-1));
        more   = run;
      end
      M_SSGL: begin
        if (nh[CW]) begin
          more = 1'b1;
          nch  = nh[CW-1:0];
        end else set_ev = 1'b1;
      end
      M_SCONT: begin
        more = run;
        if (nh[CW]) nch = nh[CW-1:0];
        else begin
          set_ev = 1'b1;
          nch    = low[CW-1:0];
        end
      end
      M_PAIR: begin
        dest   = slot_q;
        set_ev = (slot_q == CW'(NCH-1));
        more   = run;
        nch    = slot_q[0] ? a_q : b_q;
      end
      M_STEP: set_ev = 1'b1;
      default: set_ev = 1'b0;
    endcase
  end

  wire fin = busy && conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      md_q       <= '0;
      msk_q      <= '0;
      a_q        <= '0;
      b_q        <= '0;
      slot_q     <= '0;
      ptr_q      <= '0;
      pend_q     <= 1'b0;
      for (int i = 0; i < NCH; i++) rg[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      if (!busy && start && go_ok) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        conv_ch    <= go_ch;
        md_q       <= mode;
        msk_q      <= scan_mask;
        a_q        <= fix_ch;
        b_q        <= pair_ch;
        slot_q     <= '0;
      end else if (fin) begin
        rg[dest] <= conv_data;
        slot_q   <= slot_q + CW'(1);
        if (md_q == M_STEP) ptr_q <= conv_ch + CW'(1);
        if (more) begin
          conv_start <= 1'b1;
          conv_ch    <= nch;
        end else busy <= 1'b0;
      end
      if (fin && set_ev) pend_q <= 1'b1;
      else if (irq_clr)  pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_res
    assign res[g*DW +: DW] = rg[g];
  end

  assign irq = pend_q && irq_en;
endmodule

module adc_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          conv_start,
  input logic          conv_done,
  input logic          busy,
  input logic          irq,
  input logic          irq_en,
  input logic          irq_clr,
  input logic [4*DW-1:0] res
);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !conv_done) |=> !conv_start);

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(res));

  assert_stop_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(conv_done) || $rose(irq_en)));

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !conv_done) |=> !irq);
endmodule

bind adc_seq adc_seq_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int DW  = 8;
  localparam int LAT = 5;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic [1:0] fix_ch = 0, pair_ch = 0;
  logic [3:0] scan_mask = 0;
  logic start = 0, run = 0, irq_en = 1, group_irq_sel = 0, irq_clr = 0;
  logic conv_start, conv_done = 0, busy, irq;
  logic [1:0] conv_ch;
  logic [DW-1:0] conv_data = 0;
  logic [4*DW-1:0] res;

  adc_seq #(.DW(DW)) i_adc_seq (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, done_cnt = 0, seq = 0;
  string cur_req = "R1";
  int q_ch[$], q_slot[$];
  string q_req[$];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic expect_conv(input int ch, input int slot, input string r);
    q_ch.push_back(ch); q_slot.push_back(slot); q_req.push_back(r);
  endtask

  // converter model and scoreboard monitor
  always begin
    @(negedge clk);
    while (conv_start) begin
      int ch, slot;
      string r;
      logic [DW-1:0] d;
      ch = int'(conv_ch);
      if (q_ch.size() == 0) begin
        chk(0, {cur_req, " unexpected conversion"}, ch, -1);
        slot = -1; r = cur_req;
      end else begin
        r = q_req.pop_front();
        slot = q_slot.pop_front();
        chk(ch == q_ch[0], {r, " channel"}, ch, q_ch[0]);
        void'(q_ch.pop_front());
      end
      repeat (LAT) @(negedge clk);
      seq++;
      d = {2'(ch), 6'(seq)};
      conv_data = d; conv_done = 1;
      @(negedge clk);
      conv_done = 0;
      if (slot >= 0) chk(res[slot*DW +: DW] == d, {r, " result slot"}, int'(res[slot*DW +: DW]), int'(d));
      done_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0; #1;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; #1;
  endtask

  task automatic wait_done(input int k);
    while (done_cnt < k) begin @(negedge clk); #1; end
  endtask

  task automatic finish_seq(input string r);
    while (busy) begin @(negedge clk); #1; end
    tick(8);
    chk(q_ch.size() == 0, {r, " missing conversions"}, q_ch.size(), 0);
    chk(busy == 0, {r, " idle"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    tick(3);
    rst_n = 1;
    tick(2);
    chk(res == 0, "R1 reset results", int'(res), 0);
    chk(irq == 0 && busy == 0 && conv_start == 0, "R11 reset flags", {irq, busy, conv_start}, 0);

    // R1 fixed single
    cur_req = "R1"; mode = 0; fix_ch = 2; b = done_cnt;
    expect_conv(2, 2, "R1");
    pulse_start(); wait_done(b + 1);
    chk(irq == 1, "R1 irq after single", irq, 1);
    finish_seq("R1");
    chk(irq == 1, "R11 sticky", irq, 1);
    clr_irq();
    chk(irq == 0, "R11 cleared", irq, 0);

    // R2 R3 fixed continuous with group interrupt, R9 stop
    cur_req = "R9"; mode = 1; fix_ch = 1; group_irq_sel = 1; run = 1; b = done_cnt;
    for (int i = 0; i < 8; i++) expect_conv(1, i % 4, "R2");
    pulse_start();
    wait_done(b + 3);
    chk(irq == 0, "R3 no irq before group", irq, 0);
    wait_done(b + 4);
    chk(irq == 1, "R3 irq at group", irq, 1);
    clr_irq();
    wait_done(b + 7);
    chk(irq == 0, "R3 no irq mid second group", irq, 0);
    run = 0;
    wait_done(b + 8);
    chk(irq == 1, "R3 irq second group", irq, 1);
    finish_seq("R9");
    clr_irq();

    // R3 group interrupt deselected
    cur_req = "R3"; group_irq_sel = 0; run = 1; fix_ch = 0; b = done_cnt;
    for (int i = 0; i < 4; i++) expect_conv(0, i, "R3");
    pulse_start();
    wait_done(b + 3); run = 0;
    wait_done(b + 4);
    finish_seq("R3");
    chk(irq == 0, "R3 irq deselected", irq, 0);

    // R4 scan single
    cur_req = "R4"; mode = 2; scan_mask = 4'b1011; b = done_cnt;
    expect_conv(0, 0, "R4"); expect_conv(1, 1, "R4"); expect_conv(3, 3, "R4");
    pulse_start();
    wait_done(b + 2);
    chk(irq == 0, "R4 no irq before last", irq, 0);
    wait_done(b + 3);
    chk(irq == 1, "R4 irq after last", irq, 1);
    finish_seq("R4");
    clr_irq();
    scan_mask = 4'b0100; b = done_cnt;
    expect_conv(2, 2, "R4");
    pulse_start(); wait_done(b + 1);
    chk(irq == 1, "R4 single channel irq", irq, 1);
    finish_seq("R4");
    clr_irq();

    // R5 scan continuous
    cur_req = "R5"; mode = 3; scan_mask = 4'b0110; run = 1; b = done_cnt;
    for (int i = 0; i < 3; i++) begin expect_conv(1, 1, "R5"); expect_conv(2, 2, "R5"); end
    pulse_start();
    wait_done(b + 1);
    chk(irq == 0, "R5 no irq mid pass", irq, 0);
    wait_done(b + 2);
    chk(irq == 1, "R5 irq end of pass", irq, 1);
    clr_irq();
    wait_done(b + 5); run = 0;
    wait_done(b + 6);
    finish_seq("R5");
    clr_irq();

    // R6 paired continuous
    cur_req = "R6"; mode = 4; fix_ch = 3; pair_ch = 0; run = 1; b = done_cnt;
    for (int i = 0; i < 8; i++) expect_conv((i % 2) ? 0 : 3, i % 4, "R6");
    pulse_start();
    wait_done(b + 3);
    chk(irq == 0, "R6 no irq before four", irq, 0);
    wait_done(b + 4);
    chk(irq == 1, "R6 irq after four", irq, 1);
    clr_irq();
    wait_done(b + 7); run = 0;
    wait_done(b + 8);
    finish_seq("R6");
    clr_irq();

    // R7 stepped scan
    cur_req = "R7"; mode = 5; scan_mask = 4'b1010;
    for (int i = 0; i < 3; i++) begin
      int c;
      c = (i == 1) ? 3 : 1;
      b = done_cnt;
      expect_conv(c, c, "R7");
      pulse_start(); wait_done(b + 1);
      chk(irq == 1, "R7 irq per step", irq, 1);
      finish_seq("R7");
      clr_irq();
    end

    // R8 empty mask
    cur_req = "R8"; scan_mask = 0;
    mode = 2; pulse_start(); tick(10);
    mode = 5; pulse_start(); tick(10);
    mode = 3; run = 1; pulse_start(); tick(10); run = 0;
    chk(busy == 0, "R8 not busy", busy, 0);
    chk(irq == 0, "R8 no irq", irq, 0);

    // R10 start during conversion
    cur_req = "R10"; mode = 0; fix_ch = 0; b = done_cnt;
    expect_conv(0, 0, "R10");
    pulse_start(); tick(1); pulse_start();
    wait_done(b + 1);
    finish_seq("R10");
    chk(done_cnt == b + 1, "R10 one conversion", done_cnt - b, 1);
    clr_irq();

    // R11 masked interrupt
    cur_req = "R11"; irq_en = 0; fix_ch = 3; b = done_cnt;
    expect_conv(3, 3, "R11");
    pulse_start(); wait_done(b + 1);
    finish_seq("R11");
    chk(irq == 0, "R11 masked", irq, 0);
    @(negedge clk); irq_en = 1; #1;
    chk(irq == 1, "R11 pending shows when enabled", irq, 1);
    clr_irq();
    chk(irq == 0, "R11 cleared", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule